// File: doc/BRIEF.md
# Buffered Four-Channel Input Capture

The block timestamps events on four input pins. The timestamps come from a shared free-running counter. The counter itself is generated outside the block and arrives on a bus.

Each pin first passes through a two-flop synchronizer. It then goes to an edge detector whose polarity is set per channel. When the chosen edge is seen, the channel stores the counter value in its capture register and sets its capture flag. Software clears a flag by writing 0 to it. Each channel has an enable bit, and an enabled flag drives a shared, level-sensitive interrupt line.

Two buffer controls turn channels C and D into history registers for A and B. With the A buffer on, every capture on A moves the old A value into C in the same clock edge that loads A. Channel C then keeps the previous timestamp while A holds the newest one. The B buffer pairs B and D in the same way. While a buffer is on, edges on the pin of the history channel still set its flag, but they no longer load its register.

Top module: `icap_quad`

## Requirements
- R1: After reset all four capture registers read 16'h0000, all capture flags read 0 and the interrupt line is 0.
- R2: With edge select 1, a rising edge on a channel pin captures the counter and sets the flag. A falling edge on that pin changes neither the register nor the flag.
- R3: With edge select 0, a falling edge on a channel pin captures the counter and sets the flag. A rising edge on that pin changes neither the register nor the flag.
- R4: Suppose a pin changes between two clock edges, and the pin change is a selected edge. The capture register and flag update on the third rising clock edge after that change. The register takes the counter value present just before that third edge.
- R5: A flag write strobe with data bit 0 clears that flag at the next clock edge. A strobe with data bit 1 leaves the flag unchanged.
- R6: If a capture and a flag clear hit the same channel at the same clock edge, the flag ends at 1.
- R7: The interrupt output is 1 exactly when at least one channel has both its flag and its enable bit at 1. It falls as soon as no such pair remains.
- R8: With buffer control bit 0 at 1, a capture on A loads the new counter value into register A. In the same clock edge it loads the previous register A value into register C.
- R9: With buffer control bit 1 at 1, a capture on B loads the new counter value into register B. In the same clock edge it loads the previous register B value into register D.
- R10: While a buffer bit is on, a selected edge on the pin of the paired history channel (C for bit 0, D for bit 1) sets that channel's flag and leaves its register unchanged.
- R11: With both buffer bits at 0, channels C and D capture from their own pins, and captures on A or B leave registers C and D unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 16 | Shared free-running counter value |
| pin_i | input | 4 | Capture pins; bit 0 = A, 1 = B, 2 = C, 3 = D |
| edge_sel_i | input | 4 | Per-channel edge select: 1 = rising, 0 = falling |
| irq_en_i | input | 4 | Per-channel interrupt enable |
| buf_en_i | input | 2 | Bit 0 chains C behind A; bit 1 chains D behind B |
| flag_wr_i | input | 4 | Per-channel flag write strobe |
| flag_wdata_i | input | 4 | Flag write data; 0 clears, 1 has no effect |
| cap_a_o | output | 16 | Capture register A |
| cap_b_o | output | 16 | Capture register B |
| cap_c_o | output | 16 | Capture register C |
| cap_d_o | output | 16 | Capture register D |
| flag_o | output | 4 | Capture flags, same bit order as pin_i |
| irq_o | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear that lands on exactly the same clock edge as a capture on that channel. The capture edge lies three clock edges behind the pin change.

To reach it, the bench changes the pin half a cycle before an edge and waits for two rising edges. It then raises the clear strobe for one cycle, so that the strobe and the detected edge meet at the third edge. The buffered shift also needs care. The bench records register A before the capture and compares register C against that recorded value afterwards. It does this over two consecutive captures, so a stale or doubled shift would be caught.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int NCH  = 4;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam int CH_C = 2;
  localparam int CH_D = 3;

  // Edge detection: rise_sel = 1 picks a low-to-high transition.
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rise_sel);
    return rise_sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Flag update: a capture takes priority over a clear.
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/icap_edge.sv
module icap_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic edge_o
);
  import icap_pkg::*;

  // STAGES synchronizer flops plus one history flop
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign edge_o = edge_hit(sh_q[STAGES-1], sh_q[STAGES], rise_sel_i);

  // R2/R3: an edge pulse lasts a single cycle when the select is held
  p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(rise_sel_i)) |=> (!edge_o || !$stable(rise_sel_i)));
endmodule

// File: rtl/icap_chan.sv
module icap_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          set_i,
  input  logic          clr_i,
  output logic [CW-1:0] cap_o,
  output logic          flag_o
);
  import icap_pkg::*;

  logic [CW-1:0] cap_q;
  logic          flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (load_i) cap_q <= val_i;
      flag_q <= flag_next(flag_q, set_i, clr_i);
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;

  p_set_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_hold_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(flag_o));
  p_hold_reg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(cap_o));
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cap_o == $past(val_i)));
endmodule

// File: rtl/icap_quad.sv
module icap_quad #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [3:0]       pin_i,
  input  logic [3:0]       edge_sel_i,
  input  logic [3:0]       irq_en_i,
  input  logic [1:0]       buf_en_i,
  input  logic [3:0]       flag_wr_i,
  input  logic [3:0]       flag_wdata_i,
  output logic [CNT_W-1:0] cap_a_o,
  output logic [CNT_W-1:0] cap_b_o,
  output logic [CNT_W-1:0] cap_c_o,
  output logic [CNT_W-1:0] cap_d_o,
  output logic [3:0]       flag_o,
  output logic             irq_o
);
  import icap_pkg::*;

  // Named internal events, visible to the assertions
  logic [NCH-1:0]            evt;
  logic [NCH-1:0]            load;
  logic [NCH-1:0]            clr;
  logic [NCH-1:0]            flag;
  logic [NCH-1:0][CNT_W-1:0] val;
  logic [NCH-1:0][CNT_W-1:0] cap;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      icap_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i[gi]),
        .rise_sel_i(edge_sel_i[gi]), .edge_o(evt[gi]));

      assign clr[gi] = flag_wr_i[gi] & ~flag_wdata_i[gi];

      icap_chan #(.CW(CNT_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .load_i(load[gi]), .val_i(val[gi]),
        .set_i(evt[gi]), .clr_i(clr[gi]), .cap_o(cap[gi]), .flag_o(flag[gi]));
    end
  endgenerate

  // Load routing: C and D take the previous A and B values in buffer mode
  always_comb begin
    load[CH_A] = evt[CH_A];
    val[CH_A]  = cnt_i;
    load[CH_B] = evt[CH_B];
    val[CH_B]  = cnt_i;
    if (buf_en_i[0]) begin
      load[CH_C] = evt[CH_A];
      val[CH_C]  = cap[CH_A];
    end else begin
      load[CH_C] = evt[CH_C];
      val[CH_C]  = cnt_i;
    end
    if (buf_en_i[1]) begin
      load[CH_D] = evt[CH_B];
      val[CH_D]  = cap[CH_B];
    end else begin
      load[CH_D] = evt[CH_D];
      val[CH_D]  = cnt_i;
    end
  end

  assign cap_a_o = cap[CH_A];
  assign cap_b_o = cap[CH_B];
  assign cap_c_o = cap[CH_C];
  assign cap_d_o = cap[CH_D];
  assign flag_o  = flag;
  assign irq_o   = |(flag & irq_en_i);

  p_buf_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en_i[0] && evt[CH_A]) |=> (cap_c_o == $past(cap_a_o)));
  p_buf_shift_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en_i[1] && evt[CH_B]) |=> (cap_d_o == $past(cap_b_o)));
  p_buf_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_en_i[0] && evt[CH_C] && !evt[CH_A]) |=> ($stable(cap_c_o) && flag_o[CH_C]));
  p_nobuf_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en_i[0] && !evt[CH_C]) |=> $stable(cap_c_o));
  p_collide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[CH_A] && clr[CH_A]) |=> flag_o[CH_A]);
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o |-> ($countones(flag_o & irq_en_i) > 0)));
endmodule

// File: tb/sim_icap_quad.sv
module sim_icap_quad;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h0100;
  logic [3:0]  pin = '0, esel = '0, ien = '0, fwr = '0, fwd = '0;
  logic [1:0]  buf_en = '0;
  logic [15:0] cap_a, cap_b, cap_c, cap_d;
  logic [3:0]  flag;
  logic        irq;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) cnt <= cnt + 16'd3;

  icap_quad u0 (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pin_i(pin), .edge_sel_i(esel),
    .irq_en_i(ien), .buf_en_i(buf_en), .flag_wr_i(fwr), .flag_wdata_i(fwd),
    .cap_a_o(cap_a), .cap_b_o(cap_b), .cap_c_o(cap_c), .cap_d_o(cap_d),
    .flag_o(flag), .irq_o(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd(input int ch);
    case (ch)
      0: return cap_a;
      1: return cap_b;
      2: return cap_c;
      default: return cap_d;
    endcase
  endfunction

  // Drive a pin level at a negedge. The capture lands on the third rising edge,
  // holding the counter value present before that edge (two increments later).
  task automatic drive(input int ch, input logic lvl, output logic [15:0] exp);
    pin[ch] = lvl;
    exp = cnt + 16'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_flag(input int ch, input logic d);
    fwr[ch] = 1'b1; fwd[ch] = d;
    @(negedge clk);
    fwr[ch] = 1'b0; fwd[ch] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 cap_a", cap_a, 16'h0); chk("R1 cap_b", cap_b, 16'h0);
    chk("R1 cap_c", cap_c, 16'h0); chk("R1 cap_d", cap_d, 16'h0);
    chk("R1 flags", {12'h0, flag}, 16'h0); chk("R1 irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic t_rise;
    logic [15:0] e, keep;
    esel = 4'b1101;
    drive(0, 1'b1, e);
    chk("R4 rise value A", cap_a, e);
    chk("R2 flag A set", {15'h0, flag[0]}, 16'h1);
    chk("R2 others idle", {12'h0, flag[3:1]}, 16'h0);
    keep = cap_a;
    wr_flag(0, 1'b0);
    drive(0, 1'b0, e);
    chk("R2 falling ignored reg", cap_a, keep);
    chk("R2 falling ignored flag", {15'h0, flag[0]}, 16'h0);
  endtask

  task automatic t_fall;
    logic [15:0] e;
    drive(1, 1'b1, e);
    chk("R3 rising ignored reg", cap_b, 16'h0);
    chk("R3 rising ignored flag", {15'h0, flag[1]}, 16'h0);
    drive(1, 1'b0, e);
    chk("R3 falling value B", cap_b, e);
    chk("R3 flag B set", {15'h0, flag[1]}, 16'h1);
  endtask

  task automatic t_flag;
    wr_flag(1, 1'b1);
    chk("R5 write 1 keeps", {15'h0, flag[1]}, 16'h1);
    wr_flag(1, 1'b0);
    chk("R5 write 0 clears", {15'h0, flag[1]}, 16'h0);
  endtask

  task automatic t_irq;
    logic [15:0] e;
    ien = 4'b0000;
    drive(0, 1'b1, e);
    chk("R7 disabled no irq", {15'h0, irq}, 16'h0);
    ien = 4'b0001; #1;
    chk("R7 enabled irq", {15'h0, irq}, 16'h1);
    ien = 4'b1110; #1;
    chk("R7 other enables no irq", {15'h0, irq}, 16'h0);
    ien = 4'b0001;
    @(negedge clk);
    wr_flag(0, 1'b0);
    chk("R7 clear drops irq", {15'h0, irq}, 16'h0);
    ien = 4'b0000;
  endtask

  task automatic t_collide;
    logic [15:0] e;
    pin[0] = 1'b0;
    repeat (4) @(negedge clk);
    pin[0] = 1'b1;
    e = cnt + 16'd6;
    repeat (2) @(posedge clk);
    @(negedge clk);
    fwr[0] = 1'b1; fwd[0] = 1'b0;
    @(posedge clk);
    @(negedge clk);
    fwr[0] = 1'b0;
    chk("R6 capture beats clear flag", {15'h0, flag[0]}, 16'h1);
    chk("R6 capture value", cap_a, e);
    wr_flag(0, 1'b0);
  endtask

  task automatic t_nobuf;
    logic [15:0] e, keep;
    buf_en = 2'b00;
    drive(2, 1'b1, e);
    chk("R11 C own capture", cap_c, e);
    keep = cap_c;
    drive(0, 1'b0, e);
    drive(0, 1'b1, e);
    chk("R11 A capture leaves C", cap_c, keep);
  endtask

  task automatic t_bufa;
    logic [15:0] e, olda;
    buf_en = 2'b01;
    pin[0] = 1'b0; repeat (4) @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      olda = cap_a;
      drive(0, 1'b1, e);
      chk("R8 new A", cap_a, e);
      chk("R8 old A into C", cap_c, olda);
      pin[0] = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic t_bufb;
    logic [15:0] e, oldb;
    buf_en = 2'b11;
    pin[1] = 1'b1; repeat (4) @(negedge clk);
    oldb = cap_b;
    drive(1, 1'b0, e);
    chk("R9 new B", cap_b, e);
    chk("R9 old B into D", cap_d, oldb);
  endtask

  task automatic t_bufpin;
    logic [15:0] e, kc, kd;
    wr_flag(2, 1'b0); wr_flag(3, 1'b0);
    pin[2] = 1'b0; repeat (4) @(negedge clk);
    kc = cap_c; kd = cap_d;
    drive(2, 1'b1, e);
    chk("R10 C pin no load", cap_c, kc);
    chk("R10 C pin flag", {15'h0, flag[2]}, 16'h1);
    drive(3, 1'b1, e);
    chk("R10 D pin no load", cap_d, kd);
    chk("R10 D pin flag", {15'h0, flag[3]}, 16'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_flag();
    t_irq();
    t_collide();
    t_nobuf();
    t_bufa();
    t_bufb();
    t_bufpin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule